// File: doc/BRIEF.md
# Vector Length Control Unit

This block holds the two values that govern how many elements a vector operation touches: the current vector length (VL) and the largest length the loop may reach (MAXVL). Each value is kept in a 6-bit field. MAXVL is stored as its value minus one, so it covers 1 to 64. VL is stored so that the all-zero pattern stands for 64. One extra flag bit marks the empty length, which lets VL also take the value 0.

Three kinds of update reach the block:

- A control-register write that carries a full register operand.
- A control-register write that carries a 5-bit immediate, which only reaches 1 to 32.
- A set-length operation. It loads MAXVL from an immediate and sets VL to the smaller of the requested count and that maximum.

A set-length request of zero yields VL = 0 and raises a flag. A branch placed right after the operation can use that flag to skip the loop body. The decoded 7-bit values and the raw encodings are always visible on the outputs.

Top module: `vlen_ctrl`

## Requirements
- R1: While reset is held and in the cycle after release, VL reads 1, MAXVL reads 64 and the zero flag is low.
- R2: The encoding outputs follow the values at all times. The MAXVL encoding equals MAXVL minus 1. The VL encoding equals VL modulo 64, so 64 and 0 both encode as 0. The zero flag is high exactly when VL is 0.
- R3: A register write to VL (cmdOp = 0, csrSel = 0) treats an operand of 0 as 64 and saturates operands above 64 to 64. It then clamps the result to the current MAXVL.
- R4: An immediate write (cmdOp = 1) turns the 5-bit field i into the value i+1 (1 to 32). It applies that value to VL when csrSel = 0 and to MAXVL when csrSel = 1, with the same clamping rules as the register form.
- R5: A register write to MAXVL (cmdOp = 0, csrSel = 1) maps 0 and values above 64 to 64. If VL is above the new MAXVL, VL drops to it. A VL of 0 stays 0.
- R6: A set-length operation (cmdOp = 2) sets MAXVL to setMaxImm+1 and VL to min(setReq, new MAXVL). csrSel is ignored.
- R7: A set-length request of 0 gives VL = 0 with the zero flag high. No other command can make VL zero.
- R8: VL never exceeds MAXVL, and MAXVL is never below 1.
- R9: With cmdValid low, or with the reserved code cmdOp = 3, every output keeps its value.
- R10: A command sampled on a rising edge shows on the outputs right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 2 | 0 register write, 1 immediate write, 2 set-length, 3 reserved |
| csrSel | input | 1 | Target of a write: 0 VL, 1 MAXVL |
| csrData | input | XLEN | Register operand of a register write |
| csrImm | input | IMMW | Immediate of an immediate write (value = field + 1) |
| setReq | input | XLEN | Requested element count of a set-length operation |
| setMaxImm | input | LENW | Set-length maximum, encoded as MAXVL - 1 |
| vlVal | output | LENW+1 | Decoded VL, 0 to 64 |
| maxVlVal | output | LENW+1 | Decoded MAXVL, 1 to 64 |
| vlEnc | output | LENW | Stored VL encoding |
| maxVlEnc | output | LENW | Stored MAXVL encoding |
| vlZero | output | 1 | VL is zero, for branch-over of a loop |

## Verification
Several properties are checked by assertions on every cycle:

- VL stays at or below MAXVL.
- Only a set-length operation can raise the zero flag.
- Idle and reserved commands leave the state untouched.
- A set-length loads its maximum.
- An immediate VL write never exceeds 32.

Other behaviour is shown only by the bench's scenarios, which compare against a behavioural model:

- How zero and oversized operands map to 64.
- The clamp of VL when MAXVL shrinks.
- The survival of VL = 0 across a MAXVL write.
- The exact modulo encoding of 64.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

  typedef enum logic [1:0] {
    OP_CSR_REG = 2'd0,
    OP_CSR_IMM = 2'd1,
    OP_SETVL   = 2'd2,
    OP_RSVD    = 2'd3
  } vlenOp_e;

  // strobes from the command decoder to the length datapath
  typedef struct packed {
    logic wrVl;    // write VL from a CSR operand
    logic wrMax;   // write MAXVL from a CSR operand
    logic setvl;   // set-length: load MAXVL and clamp request
    logic useImm;  // CSR operand comes from the immediate field
  } vlenStrobe_t;

endpackage

// File: rtl/vlen_decode.sv
module vlen_decode
  import vlen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic        csrSel,
  output vlenStrobe_t strb
);

  vlenOp_e op;

  always_comb begin
    op   = vlenOp_e'(cmdOp);
    strb = '0;
    if (cmdValid) begin
      unique case (op)
        OP_CSR_REG: begin
          strb.wrVl  = !csrSel;
          strb.wrMax = csrSel;
        end
        OP_CSR_IMM: begin
          strb.wrVl   = !csrSel;
          strb.wrMax  = csrSel;
          strb.useImm = 1'b1;
        end
        OP_SETVL: strb.setvl = 1'b1;
        default:  strb = '0;
      endcase
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrVl, strb.wrMax, strb.setvl})); // R9

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid || cmdOp == 2'd3) |-> !(strb.wrVl || strb.wrMax || strb.setvl)); // R9

endmodule

// File: rtl/vlen_regs.sv
module vlen_regs
  import vlen_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LENW = 6,
  parameter int IMMW = 5,
  localparam int VALW = LENW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  vlenStrobe_t       strb,
  input  logic [XLEN-1:0]   csrData,
  input  logic [IMMW-1:0]   csrImm,
  input  logic [XLEN-1:0]   setReq,
  input  logic [LENW-1:0]   setMaxImm,
  output logic [VALW-1:0]   vlVal,
  output logic [VALW-1:0]   maxVlVal,
  output logic [LENW-1:0]   vlEnc,
  output logic [LENW-1:0]   maxVlEnc,
  output logic              vlZero
);

  localparam logic [VALW-1:0] MAXLEN = VALW'(1 << LENW);
  localparam logic [VALW-1:0] ONE    = VALW'(1);

  logic [LENW-1:0] vlEncQ, maxEncQ;
  logic            zeroQ;
  logic [VALW-1:0] curVl, curMax, immVal, regVal, srcVal;
  logic [VALW-1:0] setMax, setVl, nxtVl, nxtMax;
  logic            anyWr;

  // decode stored encodings into plain lengths
  always_comb begin
    curMax = {1'b0, maxEncQ} + ONE;
    if (zeroQ)              curVl = '0;
    else if (vlEncQ == '0)  curVl = MAXLEN;
    else                    curVl = {1'b0, vlEncQ};
  end

  // operand shaping: immediate offset, register saturation
  always_comb begin
    immVal = VALW'(csrImm) + ONE;
    if (csrData == '0 || csrData > XLEN'(MAXLEN)) regVal = MAXLEN;
    else                                           regVal = csrData[VALW-1:0];
    srcVal = strb.useImm ? immVal : regVal;
    setMax = {1'b0, setMaxImm} + ONE;
    setVl  = (setReq > XLEN'(setMax)) ? setMax : setReq[VALW-1:0];
  end

  // next-state selection
  always_comb begin
    nxtVl  = curVl;
    nxtMax = curMax;
    if (strb.setvl) begin
      nxtMax = setMax;
      nxtVl  = setVl;
    end else if (strb.wrVl) begin
      nxtVl = (srcVal > curMax) ? curMax : srcVal;
    end else if (strb.wrMax) begin
      nxtMax = srcVal;
      nxtVl  = (curVl > srcVal) ? srcVal : curVl;
    end
  end

  assign anyWr = strb.setvl | strb.wrVl | strb.wrMax;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlEncQ  <= LENW'(1);
      maxEncQ <= '1;
      zeroQ   <= 1'b0;
    end else if (anyWr) begin
      vlEncQ  <= nxtVl[LENW-1:0];
      maxEncQ <= LENW'(nxtMax - ONE);
      zeroQ   <= (nxtVl == '0);
    end
  end

  assign vlVal    = curVl;
  assign maxVlVal = curMax;
  assign vlEnc    = vlEncQ;
  assign maxVlEnc = maxEncQ;
  assign vlZero   = zeroQ;

  AST_VL_LE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    vlVal <= maxVlVal); // R8

  AST_ZERO_FROM_SETVL: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && $rose(zeroQ)) |-> $past(strb.setvl)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !anyWr |=> ($stable(vlEncQ) && $stable(maxEncQ) && $stable(zeroQ))); // R9

  AST_IMM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrVl && strb.useImm) |=> (vlVal <= VALW'(1 << IMMW) && vlVal != '0)); // R4

  AST_SETVL_MAX: assert property (@(posedge clk) disable iff (!rstN)
    strb.setvl |=> maxEncQ == $past(setMaxImm)); // R6

endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LENW = 6,
  parameter int IMMW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              csrSel,
  input  logic [XLEN-1:0]   csrData,
  input  logic [IMMW-1:0]   csrImm,
  input  logic [XLEN-1:0]   setReq,
  input  logic [LENW-1:0]   setMaxImm,
  output logic [LENW:0]     vlVal,
  output logic [LENW:0]     maxVlVal,
  output logic [LENW-1:0]   vlEnc,
  output logic [LENW-1:0]   maxVlEnc,
  output logic              vlZero
);

  vlenStrobe_t strb;

  vlen_decode u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .csrSel   (csrSel),
    .strb     (strb)
  );

  vlen_regs #(
    .XLEN (XLEN),
    .LENW (LENW),
    .IMMW (IMMW)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .csrData   (csrData),
    .csrImm    (csrImm),
    .setReq    (setReq),
    .setMaxImm (setMaxImm),
    .vlVal     (vlVal),
    .maxVlVal  (maxVlVal),
    .vlEnc     (vlEnc),
    .maxVlEnc  (maxVlEnc),
    .vlZero    (vlZero)
  );

endmodule

// File: tb/vlen_ctrl_tb_top.sv
module vlen_ctrl_tb_top;

  localparam int XLEN = 64;
  localparam int LENW = 6;
  localparam int IMMW = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdValid = 1'b0;
  logic [1:0]      cmdOp = 2'd0;
  logic            csrSel = 1'b0;
  logic [XLEN-1:0] csrData = '0;
  logic [IMMW-1:0] csrImm = '0;
  logic [XLEN-1:0] setReq = '0;
  logic [LENW-1:0] setMaxImm = '0;
  logic [LENW:0]   vlVal, maxVlVal;
  logic [LENW-1:0] vlEnc, maxVlEnc;
  logic            vlZero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int mVl  = 1;
  int mMax = 64;

  always #2.5 clk = ~clk;

  vlen_ctrl #(.XLEN(XLEN), .LENW(LENW), .IMMW(IMMW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .csrSel(csrSel),
    .csrData(csrData), .csrImm(csrImm), .setReq(setReq), .setMaxImm(setMaxImm),
    .vlVal(vlVal), .maxVlVal(maxVlVal), .vlEnc(vlEnc), .maxVlEnc(maxVlEnc),
    .vlZero(vlZero)
  );

  function automatic int satOp(logic [XLEN-1:0] d);
    if (d == 0 || d > 64) return 64;
    return int'(d);
  endfunction

  // behavioural model of one clock with the current inputs
  task automatic modelStep();
    int v;
    if (!cmdValid || cmdOp == 2'd3) return;
    if (cmdOp == 2'd2) begin
      mMax = int'(setMaxImm) + 1;
      mVl  = (setReq > 64'(mMax)) ? mMax : int'(setReq);
    end else begin
      v = (cmdOp == 2'd1) ? int'(csrImm) + 1 : satOp(csrData);
      if (!csrSel) mVl = (v > mMax) ? mMax : v;
      else begin
        mMax = v;
        if (mVl > v) mVl = v;
      end
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (int'(vlVal) != mVl || int'(maxVlVal) != mMax || vlZero != (mVl == 0)) begin
      fails++;
      $display("FAIL %s: vl=%0d max=%0d zero=%0b expected vl=%0d max=%0d zero=%0b",
               tag, vlVal, maxVlVal, vlZero, mVl, mMax, mVl == 0);
    end
    checks++;
    if (int'(vlEnc) != (mVl % 64) || int'(maxVlEnc) != mMax - 1) begin
      fails++;
      $display("FAIL R2: vlEnc=%0d maxEnc=%0d expected %0d %0d",
               vlEnc, maxVlEnc, mVl % 64, mMax - 1);
    end
  endtask

  task automatic step(bit v, logic [1:0] op, bit sel, logic [XLEN-1:0] d,
                      logic [IMMW-1:0] im, logic [XLEN-1:0] rq,
                      logic [LENW-1:0] mx, string tag);
    cmdValid = v; cmdOp = op; csrSel = sel; csrData = d;
    csrImm = im; setReq = rq; setMaxImm = mx;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    cmdValid = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R3: register write to VL
    step(1, 2'd0, 0, 64'd17, 0, 0, 0, "R3 plain");
    step(1, 2'd0, 0, 64'd0, 0, 0, 0, "R3 zero->64");
    step(1, 2'd0, 0, 64'd1000, 0, 0, 0, "R3 large->64");
    // R5: shrink MAXVL, VL follows
    step(1, 2'd0, 1, 64'd20, 0, 0, 0, "R5 shrink");
    step(1, 2'd0, 0, 64'd40, 0, 0, 0, "R3 clamp to max");
    step(1, 2'd0, 1, 64'd0, 0, 0, 0, "R5 zero->64");
    // R4: immediate forms
    step(1, 2'd1, 0, 0, 5'd31, 0, 0, "R4 imm 32");
    step(1, 2'd1, 0, 0, 5'd0, 0, 0, "R4 imm 1");
    step(1, 2'd1, 1, 0, 5'd9, 0, 0, "R4 imm max 10");
    step(1, 2'd1, 0, 0, 5'd20, 0, 0, "R4 imm clamp");
    // R6/R7: set-length
    step(1, 2'd2, 1, 0, 0, 64'd100, 6'd63, "R6 clamp 64");
    step(1, 2'd2, 0, 0, 0, 64'd7, 6'd15, "R6 under max");
    step(1, 2'd2, 0, 0, 0, 64'd16, 6'd15, "R6 at max");
    step(1, 2'd2, 0, 0, 0, 64'd0, 6'd31, "R7 zero request");
    step(1, 2'd0, 1, 64'd8, 0, 0, 0, "R5 zero kept");
    // R9: idle and reserved
    step(0, 2'd0, 0, 64'd3, 0, 0, 0, "R9 idle");
    step(1, 2'd3, 0, 64'd3, 5'd3, 64'd3, 6'd3, "R9 reserved");
    step(1, 2'd0, 0, 64'd5, 0, 0, 0, "R10 one-cycle update");

    for (int i = 0; i < 400; i++) begin
      logic [XLEN-1:0] d;
      d = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 80);
      step(($urandom % 5) != 0, 2'($urandom), 1'($urandom), d, 5'($urandom),
           64'($urandom % 80), 6'($urandom), "R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule